// File: doc/BRIEF.md
# DMA Channel Link Sequencer

This block supervises a group of logical DMA channels and chains them in hardware. When a channel reports the end of its block transfer, the block starts that channel's successor one cycle later without any software step. Each channel owns two 16-bit words behind a simple register port. The control word holds the channel's enable bit. The link word holds a link-enable flag, a stop flag and the index of the successor.

Software enables only the first channel of a chain. Each later channel is started by the sequencer. A chain may close on itself, either through several channels or through a single channel that names itself. It then repeats until software sets a stop flag or clears an enable bit. The transfer engines are outside the block. They report to it through one block-done pulse per channel, and the block gives each one its enable in return.

Top module: `dls_link_seq`

## Requirements
- R1: After reset every channel enable is 0, the busy output is 0, and every register reads back as 0x0000.
- R2: The register address is {channel[3:0], sel}. sel=0 selects the control word and sel=1 selects the link word. A control read returns the last written value with bit 7 replaced by the current enable. A link read returns bit 15 = link enable, bit 14 = stop, bits 3:0 = successor, and 0 in every other bit.
- R3: A control write sets the channel's enable to written bit 7 from the next cycle on. This write takes priority over any hardware start or completion for that channel in the same cycle.
- R4: A block-done pulse on an enabled channel whose link enable is 1 and stop flag is 0 requests its successor. The successor's enable rises one cycle after the cycle in which the pulse is sampled.
- R5: A completing channel clears its own enable at the clock edge that samples its block-done pulse, unless it links to itself.
- R6: A block-done pulse on a channel that is not enabled has no effect, and it starts no successor.
- R7: A channel whose stop flag is 1 starts no successor when it completes.
- R8: A start request for a channel that is already enabled is ignored and is not held for later.
- R9: A chain that loops back through several channels keeps cycling until a stop flag is set.
- R10: A channel linked to itself keeps its enable high without a gap through each completion.
- R11: A control write that disables a channel in the same cycle as its predecessor's completion discards the pending start, so the channel stays off.
- R12: The busy output is 1 exactly when at least one channel enable is 1.
- R13: When several channels complete in one cycle and name the same successor, that successor starts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address {channel, sel} |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address {channel, sel} |
| rd_data | output | 16 | Combinational read data |
| blk_done | input | 16 | Per-channel block-completion pulse |
| ch_en | output | 16 | Per-channel enable to the transfer engines |
| busy | output | 1 | OR of all channel enables |

## Verification
Two cases are hard to reach from the ports. The first is a software disable that lands in exactly the same cycle as a predecessor's completion. The second is a start request that arrives for a channel that is already running. The stimulus sets up both directly. It drives a control write and a block-done pulse in one cycle, and it turns on the successor by software before the predecessor completes. A circular chain is then torn down while it is running, by rewriting a link word between completions. Every cycle is compared against a behavioural model.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int WORD_W        = 16;
  localparam int CTRL_EN_BIT   = 7;
  localparam int LINK_EN_BIT   = 15;
  localparam int LINK_STOP_BIT = 14;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_LINK = 1'b1
  } reg_sel_e;

  // a completion passes the chain on only when linking is on and not stopped
  function automatic logic chain_open(input logic lnk_en, input logic stop);
    return lnk_en & ~stop;
  endfunction

  // control readback: stored word with the live enable in its bit slot
  function automatic logic [WORD_W-1:0] ctrl_view(input logic [WORD_W-1:0] stored,
                                                  input logic en);
    logic [WORD_W-1:0] v;
    v = stored;
    v[CTRL_EN_BIT] = en;
    return v;
  endfunction
endpackage

// File: rtl/dls_chan.sv
module dls_chan
  import dls_pkg::*;
#(
  parameter int CHW = 4,
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_link,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start_req,
  input  logic              blk_done,
  output logic              en_o,
  output logic [WORD_W-1:0] ctrl_rd,
  output logic [WORD_W-1:0] link_rd,
  output logic              fire_o,
  output logic [CHW-1:0]    succ_o,
  output logic              self_keep_o
);
  localparam logic [WORD_W-1:0] KEEP_MASK = ~(WORD_W'(1) << CTRL_EN_BIT);

  logic              en_q;
  logic [WORD_W-1:0] ctrl_q;
  logic              lnk_en_q;
  logic              stop_q;
  logic [CHW-1:0]    succ_q;
  logic              done_v;

  assign done_v      = blk_done & en_q;
  assign self_keep_o = chain_open(lnk_en_q, stop_q) && (succ_q == CHW'(IDX));
  assign fire_o      = done_v & chain_open(lnk_en_q, stop_q);
  assign succ_o      = succ_q;
  assign en_o        = en_q;
  assign ctrl_rd     = ctrl_view(ctrl_q, en_q);

  always_comb begin
    link_rd                = '0;
    link_rd[LINK_EN_BIT]   = lnk_en_q;
    link_rd[LINK_STOP_BIT] = stop_q;
    link_rd[CHW-1:0]       = succ_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ctrl_q   <= '0;
      lnk_en_q <= 1'b0;
      stop_q   <= 1'b0;
      succ_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wr_data & KEEP_MASK;
        en_q   <= wr_data[CTRL_EN_BIT];
      end else if (start_req && !en_q) begin
        en_q <= 1'b1;
      end else if (done_v && !self_keep_o) begin
        en_q <= 1'b0;
      end
      if (wr_link) begin
        lnk_en_q <= wr_data[LINK_EN_BIT];
        stop_q   <= wr_data[LINK_STOP_BIT];
        succ_q   <= wr_data[CHW-1:0];
      end
    end
  end
endmodule

// File: rtl/dls_route.sv
module dls_route #(
  parameter int NCH = 16,
  parameter int CHW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     fire,
  input  logic [NCH*CHW-1:0] succ_flat,
  input  logic [NCH-1:0]     kill,
  output logic [NCH-1:0]     start_q
);
  logic [NCH-1:0] hit;

  // target-indexed gather: channel j is requested if any firing source names it
  always_comb begin
    hit = '0;
    for (int j = 0; j < NCH; j++) begin
      for (int i = 0; i < NCH; i++) begin
        if (fire[i] && (succ_flat[i*CHW +: CHW] == CHW'(j))) hit[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else        start_q <= hit & ~kill;
  end
endmodule

// File: rtl/dls_link_seq.sv
module dls_link_seq
  import dls_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [NCH-1:0]    blk_done,
  output logic [NCH-1:0]    ch_en,
  output logic              busy
);
  logic [CHW-1:0]     wr_ch;
  logic [CHW-1:0]     rd_ch;
  reg_sel_e           wr_sel;
  reg_sel_e           rd_sel;
  logic [NCH-1:0]     wr_ctrl;
  logic [NCH-1:0]     wr_link;
  logic [NCH-1:0]     kill;
  logic [NCH-1:0]     fire;
  logic [NCH-1:0]     start_q;
  logic [NCH-1:0]     self_keep;
  logic [NCH*CHW-1:0] succ_flat;
  logic [WORD_W-1:0]  ctrl_rd [NCH];
  logic [WORD_W-1:0]  link_rd [NCH];

  assign wr_ch  = wr_addr[AW-1:1];
  assign wr_sel = reg_sel_e'(wr_addr[0]);
  assign rd_ch  = rd_addr[AW-1:1];
  assign rd_sel = reg_sel_e'(rd_addr[0]);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign wr_ctrl[g] = wr_en && (wr_ch == CHW'(g)) && (wr_sel == SEL_CTRL);
    assign wr_link[g] = wr_en && (wr_ch == CHW'(g)) && (wr_sel == SEL_LINK);
    assign kill[g]    = wr_ctrl[g] && !wr_data[CTRL_EN_BIT];

    dls_chan #(.CHW(CHW), .IDX(g)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (wr_ctrl[g]),
      .wr_link    (wr_link[g]),
      .wr_data    (wr_data),
      .start_req  (start_q[g]),
      .blk_done   (blk_done[g]),
      .en_o       (ch_en[g]),
      .ctrl_rd    (ctrl_rd[g]),
      .link_rd    (link_rd[g]),
      .fire_o     (fire[g]),
      .succ_o     (succ_flat[g*CHW +: CHW]),
      .self_keep_o(self_keep[g])
    );
  end

  dls_route #(.NCH(NCH), .CHW(CHW)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .succ_flat(succ_flat),
    .kill     (kill),
    .start_q  (start_q)
  );

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_ch == CHW'(c)) rd_data = (rd_sel == SEL_LINK) ? link_rd[c] : ctrl_rd[c];
    end
  end

  assign busy = |ch_en;
endmodule

// File: rtl/dls_link_checker.sv
module dls_link_checker #(
  parameter int NCH = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic           wr_en_bit,
  input logic [NCH-1:0] blk_done,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] start_q,
  input logic [NCH-1:0] self_keep
);
  for (genvar j = 0; j < NCH; j++) begin : g_chk
    logic wr_c;
    assign wr_c = wr_en && (wr_addr == {CHW'(j), 1'b0});

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c |=> (ch_en[j] == $past(wr_en_bit))); // R3
    AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      start_q[j] && !ch_en[j] && !wr_c |=> ch_en[j]); // R4
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done[j] && ch_en[j] && !self_keep[j] && !wr_c |=> !ch_en[j]); // R5
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[j] && !start_q[j] && !wr_c |=> !ch_en[j]); // R6
    AST_SELF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done[j] && ch_en[j] && self_keep[j] && !wr_c |=> ch_en[j]); // R10
    AST_KILL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c && !wr_en_bit |=> !start_q[j]); // R11
  end
endmodule

bind dls_link_seq dls_link_checker #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_en_bit(wr_data[dls_pkg::CTRL_EN_BIT]),
  .blk_done (blk_done),
  .ch_en    (ch_en),
  .start_q  (start_q),
  .self_keep(self_keep)
);

// File: tb/sim_dls_link_seq.sv
`timescale 1ns/1ps
module sim_dls_link_seq;
  localparam int NCH = 16;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic [NCH-1:0] blk_done = '0;
  logic [NCH-1:0] ch_en;
  logic          busy;

  always #2 clk = ~clk;

  dls_link_seq #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .blk_done(blk_done), .ch_en(ch_en), .busy(busy)
  );

  int    n_run = 0;
  int    n_fail = 0;
  string cur_tag = "R1";

  // behavioural reference
  bit       m_en  [NCH];
  bit       m_req [NCH];
  bit       m_le  [NCH];
  bit       m_st  [NCH];
  int       m_succ[NCH];
  bit [15:0] m_ctrl[NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        m_en[k] = 0; m_req[k] = 0; m_le[k] = 0; m_st[k] = 0; m_succ[k] = 0; m_ctrl[k] = 0;
      end
    end else begin
      bit nreq[NCH];
      bit nen [NCH];
      bit active[NCH];
      for (int k = 0; k < NCH; k++) begin
        active[k] = blk_done[k] && m_en[k];
        nreq[k] = 0;
      end
      for (int k = 0; k < NCH; k++)
        if (active[k] && m_le[k] && !m_st[k]) nreq[m_succ[k]] = 1;
      for (int k = 0; k < NCH; k++) begin
        bit hit_c;
        hit_c = wr_en && (int'(wr_addr >> 1) == k) && !wr_addr[0];
        if (hit_c) nen[k] = wr_data[7];
        else if (m_req[k] && !m_en[k]) nen[k] = 1;
        else if (active[k] && !(m_le[k] && !m_st[k] && m_succ[k] == k)) nen[k] = 0;
        else nen[k] = m_en[k];
        if (hit_c && !wr_data[7]) nreq[k] = 0;
      end
      if (wr_en) begin
        int ch;
        ch = int'(wr_addr >> 1);
        if (wr_addr[0]) begin
          m_le[ch] = wr_data[15]; m_st[ch] = wr_data[14]; m_succ[ch] = int'(wr_data[3:0]);
        end else begin
          m_ctrl[ch] = wr_data;
          m_ctrl[ch][7] = 1'b0;
        end
      end
      for (int k = 0; k < NCH; k++) begin
        m_en[k] = nen[k]; m_req[k] = nreq[k];
      end
    end
  end

  function automatic bit [15:0] model_read(input logic [AW-1:0] a);
    int ch;
    bit [15:0] v;
    ch = int'(a >> 1);
    v = 16'h0000;
    if (a[0]) begin
      v[15] = m_le[ch]; v[14] = m_st[ch]; v[3:0] = 4'(m_succ[ch]);
    end else begin
      v = m_ctrl[ch]; v[7] = m_en[ch];
    end
    return v;
  endfunction

  function automatic bit [NCH-1:0] model_en();
    bit [NCH-1:0] v;
    for (int k = 0; k < NCH; k++) v[k] = m_en[k];
    return v;
  endfunction

  task automatic check16(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  // every cycle: compare against the model (R12 busy rule included)
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check16("ch_en vs model", ch_en, model_en());
    check16("busy R12", {15'd0, busy}, {15'd0, (model_en() != 0)});
    check16("rd_data vs model", rd_data, model_read(rd_addr));
  endtask

  function automatic logic [AW-1:0] adr(input int ch, input bit sel);
    return AW'((ch << 1) | int'(sel));
  endfunction

  task automatic wr(input int ch, input bit sel, input logic [15:0] d);
    wr_en = 1; wr_addr = adr(ch, sel); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic done(input logic [NCH-1:0] m);
    blk_done = m;
    tick();
    blk_done = '0;
  endtask

  task automatic expect_en(input logic [15:0] e);
    check16("ch_en", ch_en, e);
  endtask

  task automatic expect_rd(input int ch, input bit sel, input logic [15:0] e);
    rd_addr = adr(ch, sel);
    #0.1;
    check16("rd_data", rd_data, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    cur_tag = "R1";
    expect_en(16'h0000);
    check16("busy R1", {15'd0, busy}, 16'h0000);
    expect_rd(3, 0, 16'h0000);
    expect_rd(3, 1, 16'h0000);

    cur_tag = "R2";
    wr(3, 0, 16'hA55A);
    expect_rd(3, 0, 16'hA55A);
    wr(3, 1, 16'hFFF6);
    expect_rd(3, 1, 16'hC006);
    wr(3, 1, 16'h0000);

    cur_tag = "R3";
    wr(3, 0, 16'h0080);
    expect_en(16'h0008);
    expect_rd(3, 0, 16'h0080);
    wr(3, 0, 16'h0000);
    expect_en(16'h0000);

    cur_tag = "R4";
    wr(2, 1, 16'h8005);
    wr(5, 1, 16'h8009);
    wr(2, 0, 16'h0080);
    expect_en(16'h0004);
    done(16'h0004);
    cur_tag = "R5";
    expect_en(16'h0000);
    cur_tag = "R4";
    tick();
    expect_en(16'h0020);
    check16("busy R12", {15'd0, busy}, 16'h0001);
    done(16'h0020);
    tick();
    expect_en(16'h0200);
    done(16'h0200);
    cur_tag = "R5";
    expect_en(16'h0000);
    tick();
    expect_en(16'h0000);
    cur_tag = "R12";
    check16("busy idle", {15'd0, busy}, 16'h0000);

    cur_tag = "R6";
    done(16'h0004);
    tick();
    expect_en(16'h0000);

    cur_tag = "R7";
    wr(2, 0, 16'h0080);
    done(16'h0004);
    tick();
    expect_en(16'h0020);
    wr(5, 1, 16'hC009);
    expect_rd(5, 1, 16'hC009);
    done(16'h0020);
    tick();
    expect_en(16'h0000);
    tick();
    expect_en(16'h0000);

    cur_tag = "R8";
    wr(5, 1, 16'h0000);
    wr(5, 0, 16'h0080);
    wr(2, 0, 16'h0080);
    expect_en(16'h0024);
    done(16'h0004);
    tick();
    expect_en(16'h0020);
    done(16'h0020);
    tick();
    expect_en(16'h0000);
    tick();
    expect_en(16'h0000);

    cur_tag = "R9";
    wr(3, 1, 16'h8004);
    wr(4, 1, 16'h8003);
    wr(3, 0, 16'h0080);
    for (int lap = 0; lap < 3; lap++) begin
      done(16'h0008);
      tick();
      expect_en(16'h0010);
      done(16'h0010);
      tick();
      expect_en(16'h0008);
    end
    wr(4, 1, 16'hC003);
    done(16'h0008);
    tick();
    expect_en(16'h0010);
    done(16'h0010);
    tick();
    expect_en(16'h0000);

    cur_tag = "R10";
    wr(7, 1, 16'h8007);
    wr(7, 0, 16'h0080);
    expect_en(16'h0080);
    for (int lap = 0; lap < 3; lap++) begin
      done(16'h0080);
      expect_en(16'h0080);
      tick();
      expect_en(16'h0080);
    end
    cur_tag = "R3";
    blk_done = 16'h0080;
    wr(7, 0, 16'h0000);
    blk_done = '0;
    expect_en(16'h0000);
    tick();
    expect_en(16'h0000);

    cur_tag = "R11";
    wr(5, 1, 16'h0000);
    wr(2, 0, 16'h0080);
    blk_done = 16'h0004;
    wr(5, 0, 16'h0000);
    blk_done = '0;
    expect_en(16'h0000);
    tick();
    expect_en(16'h0000);
    tick();
    expect_en(16'h0000);

    cur_tag = "R13";
    wr(10, 1, 16'h800C);
    wr(11, 1, 16'h800C);
    wr(10, 0, 16'h0080);
    wr(11, 0, 16'h0080);
    expect_en(16'h0C00);
    done(16'h0C00);
    expect_en(16'h0000);
    tick();
    expect_en(16'h1000);
    done(16'h1000);
    tick();
    expect_en(16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule